// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a two-wire serial slave that lets an external host read and write a bank of 8-bit run-time registers held elsewhere in the chip. It oversamples the serial clock and data lines on the system clock and recognises start and stop conditions. It compares the 7-bit device address against its own and acts on the direction bit that follows. SDA is open-drain: the block never drives it high and only asserts a pull-low enable. SCL is input only, because the block never stretches the clock.

A write transaction always loads an 8-bit register pointer first. Any further bytes in that transaction are written to the register file at the pointer, which advances after each byte. A read transaction returns register bytes starting at the stored pointer, most significant bit first, and advances the pointer once for every byte it fetches. The pointer is kept between transactions. A host can therefore set it in one write and read from it afterwards, whether the write closed with a stop and a fresh start or went straight into a repeated start. The register file sits behind a one-cycle strobe port with a combinational read-data return.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After a start, the first byte is the 7-bit device address (MSB first) followed by the direction bit (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock. On a mismatch it keeps SDA released and ignores the bus, with no strobes, until the next start or stop.
- R2: In a write transaction the first byte after the address is loaded into the register pointer and acknowledged.
- R3: Each later byte of a write transaction produces exactly one `reg_wr` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The byte is acknowledged and the pointer then advances by one.
- R4: In a read transaction each byte is fetched with one `reg_rd` pulse at the pointer. It is shifted out MSB first on SDA and the pointer advances by one for every fetched byte.
- R5: A master ACK (SDA low on the ninth clock) after a read byte makes the slave fetch and send the next byte. A master NACK ends the read, and the slave leaves SDA released.
- R6: The pointer is kept across a stop followed by a new start, so a following read begins at the stored pointer.
- R7: The pointer is kept across a repeated start that follows the pointer write, so the read begins at the stored pointer.
- R8: A start received in the middle of a byte abandons that byte without any register write and returns to address decode. The pointer is kept.
- R9: A stop received in the middle of a byte abandons that byte without any register write and releases SDA. The pointer is kept.
- R10: The pointer wraps from 0xFF to 0x00 on both reads and writes.
- R11: After reset SDA is released, neither strobe is active and the pointer (`reg_addr`) is 0x00.
- R12: The SDA pull-low enable changes only in the cycle after a synchronised SCL falling edge, start or stop. It never changes while SCL is high within a byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| reg_addr | output | 8 | Register pointer, address of the current register access |
| reg_wdata | output | 8 | Write data, valid while `reg_wr` is 1 |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register fetch strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, sampled while `reg_rd` is 1 |

## Verification
Each line change passes through two synchroniser flops. An SCL falling edge is therefore recognised in the second system cycle after it reaches the pins. The write or fetch strobe falls in that cycle, and the SDA enable and pointer take their new values at the third clock edge. The bench holds every SCL phase for six system cycles and samples SDA in the middle of the SCL-high phase, long after any response is due. Register strobes are compared against a queue of expected addresses and data on every falling clock edge, so a missing, extra or misplaced access is caught at the cycle it happens.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 8;
  localparam int unsigned DADR_W = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_IGNORE
  } slv_state_e;

endpackage

// File: rtl/i2c_rs_rstsync.sv
module i2c_rs_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q;
  logic [STAGES-1:0] sda_pipe_q;
  logic              scl_prev_q;
  logic              sda_prev_q;
  logic              scl_s;
  logic              sda_s;

  // idle bus reads high, so the chains reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s = scl_pipe_q[STAGES-1];
  assign sda_s = sda_pipe_q[STAGES-1];

  always_comb begin
    sda_lvl   = sda_s;
    scl_rise  = scl_s & ~scl_prev_q;
    scl_fall  = ~scl_s & scl_prev_q;
    start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  end

endmodule

// File: rtl/i2c_rs_ptr.sv
module i2c_rs_ptr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  input  logic         inc_i,
  output logic [W-1:0] ptr_o
);

  logic [W-1:0] ptr_q;
  logic [W-1:0] ptr_n;
  logic         ptr_en;

  always_comb begin
    ptr_en = ld_i | inc_i;
    if (ld_i) begin
      ptr_n = val_i;
    end else begin
      ptr_n = ptr_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_n;
    end
  end

  assign ptr_o = ptr_q;

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> ptr_o == $past(val_i)); // R2
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i) |=> ptr_o == $past(ptr_o) + W'(1)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !ld_i) |=> $stable(ptr_o)); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && ptr_o == '1) |=> ptr_o == '0); // R10

endmodule

// File: rtl/i2c_rs_ctrl.sv
module i2c_rs_ctrl
  import i2c_rs_pkg::*;
#(
  parameter logic [DADR_W-1:0] DEV_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ptr_ld_o,
  output logic              ptr_inc_o
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  slv_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              oe_q, oe_n;
  logic              mack_q, mack_n;

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    oe_n      = oe_q;
    mack_n    = mack_q;
    wr_o      = 1'b0;
    rd_o      = 1'b0;
    ptr_ld_o  = 1'b0;
    ptr_inc_o = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      cnt_n   = '0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      oe_n    = 1'b0;
      cnt_n   = '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_IGNORE: begin
          oe_n = 1'b0;
        end
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt_q + CNT_W'(1);
          end
          if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_n = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                oe_n    = 1'b1;
                state_n = ST_ADDR_ACK;
              end else begin
                state_n = ST_IGNORE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_ld_o = 1'b1;
              oe_n     = 1'b1;
              state_n  = ST_PTR_ACK;
            end else begin
              wr_o      = 1'b1;
              ptr_inc_o = 1'b1;
              oe_n      = 1'b1;
              state_n   = ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (sh_q[0]) begin
              rd_o      = 1'b1;
              ptr_inc_o = 1'b1;
              sh_n      = rdata_i;
              oe_n      = ~rdata_i[BYTE_W-1];
              state_n   = ST_RDAT;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            cnt_n   = '0;
            state_n = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            cnt_n = cnt_q + CNT_W'(1);
          end
          if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              oe_n    = 1'b0;
              cnt_n   = '0;
              state_n = ST_RACK;
            end else if (cnt_q != '0) begin
              sh_n = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end
          if (scl_fall) begin
            cnt_n = '0;
            if (mack_q) begin
              rd_o      = 1'b1;
              ptr_inc_o = 1'b1;
              sh_n      = rdata_i;
              oe_n      = ~rdata_i[BYTE_W-1];
              state_n   = ST_RDAT;
            end else begin
              state_n = ST_IGNORE;
            end
          end
        end
        default: begin
          state_n = ST_IDLE;
          oe_n    = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      oe_q    <= oe_n;
      mack_q  <= mack_n;
    end
  end

  assign sda_oe_o = oe_q;
  assign byte_o   = sh_q;

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !oe_q); // R1
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> oe_q); // R3
  AST_START_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_ADDR && !oe_q)); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!oe_q && state_q == ST_IDLE)); // R9
  AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> $past(scl_fall || start_det || stop_det)); // R12

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_rs_pkg::*;
#(
  parameter logic [DADR_W-1:0] DEV_ADDR    = 7'h2C,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic             reg_wr,
  output logic             reg_rd,
  input  logic [BYTE_W-1:0] reg_rdata
);

  logic              rst_n_int;
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              ptr_ld;
  logic              ptr_inc;
  logic [BYTE_W-1:0] byte_val;

  i2c_rs_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rs_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rdata_i   (reg_rdata),
    .sda_oe_o  (sda_oe),
    .wr_o      (reg_wr),
    .rd_o      (reg_rd),
    .byte_o    (byte_val),
    .ptr_ld_o  (ptr_ld),
    .ptr_inc_o (ptr_inc)
  );

  i2c_rs_ptr #(.W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ld_i  (ptr_ld),
    .val_i (byte_val[PTR_W-1:0]),
    .inc_i (ptr_inc),
    .ptr_o (reg_addr)
  );

  assign reg_wdata = byte_val;

endmodule

// File: tb/i2c_regbank_slave_tb.sv
`timescale 1ns/1ps
module i2c_regbank_slave_tb;

  localparam int Q = 6;
  localparam logic [6:0] DEV   = 7'h2C;
  localparam logic [6:0] OTHER = 7'h2D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0]  mem     [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] wq [$];
  logic [7:0]  rq [$];
  logic [15:0] w_exp;
  logic [7:0]  r_exp;
  int exp_ptr = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_line  = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regbank_slave #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

  // register file behind the port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of register strobes against the model queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_wr) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R3 unexpected register write", {16'h0, reg_addr, reg_wdata}, 32'hffff);
        end else begin
          w_exp = wq.pop_front();
          chk({reg_addr, reg_wdata} == w_exp, "R3 write address/data", {reg_addr, reg_wdata}, w_exp);
        end
      end
      if (reg_rd) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R4 unexpected register fetch", reg_addr, 32'hffff);
        end else begin
          r_exp = rq.pop_front();
          chk(reg_addr == r_exp, "R4 fetch address", reg_addr, r_exp);
        end
      end
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b, output logic lb);
    m_sda = b; qwait();
    m_scl = 1'b1; qwait();
    lb = sda_line; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic lb;
    bit clash;
    clash = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], lb);
      if (b[i] && !lb) clash = 1'b1;
    end
    send_bit(1'b1, lb);
    acked = !lb;
    chk(!clash, "R1 SDA released during master bits", clash, 0);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic lb;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, lb);
      d[i] = lb;
    end
    send_bit(!mack, lb);
  endtask

  task automatic set_ptr(input logic [7:0] p, input bit with_stop);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk(a, "R1 write address ack", a, 1);
    send_byte(p, a);
    chk(a, "R2 pointer byte ack", a, 1);
    exp_ptr = p;
    if (with_stop) bus_stop();
  endtask

  task automatic write_data(input int n, input logic [7:0] seed);
    logic a;
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 29);
      wq.push_back({8'(exp_ptr), d});
      exp_mem[exp_ptr] = d;
      exp_ptr = (exp_ptr + 1) & 255;
      send_byte(d, a);
      chk(a, "R3 data byte ack", a, 1);
    end
  endtask

  task automatic read_seq(input int n, input string tag);
    logic a;
    logic [7:0] d, e;
    bus_start();
    rq.push_back(8'(exp_ptr));
    send_byte({DEV, 1'b1}, a);
    chk(a, "R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      e = exp_mem[exp_ptr];
      exp_ptr = (exp_ptr + 1) & 255;
      if (k < n - 1) rq.push_back(8'(exp_ptr));
      recv_byte(k < n - 1, d);
      chk(d == e, tag, d, e);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R5 SDA released after NACK", sda_oe, 0);
    chk(reg_addr == 8'(exp_ptr), "R4 pointer after read", reg_addr, exp_ptr);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic a;
    logic lb;
    logic [7:0] d;
    int wr_before;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + 5);
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 SDA released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sda_oe == 1'b0 && !reg_wr && !reg_rd, "R11 quiet after reset", {sda_oe, reg_wr, reg_rd}, 0);
    chk(reg_addr == 8'h00, "R11 pointer zero after reset", reg_addr, 0);

    // R11 / R4 / R5: read from the reset pointer
    read_seq(2, "R4 read from reset pointer");

    // R2 / R3: pointer then three data bytes
    set_ptr(8'h10, 1'b0);
    write_data(3, 8'hA1);
    bus_stop();
    chk(reg_addr == 8'h13, "R3 pointer after writes", reg_addr, 8'h13);

    // R6: pointer set, stop, fresh start read
    set_ptr(8'h10, 1'b1);
    chk(reg_addr == 8'h10, "R6 pointer kept over stop", reg_addr, 8'h10);
    read_seq(4, "R6 read after stop and start");

    // R7: pointer set, repeated start read
    set_ptr(8'h40, 1'b0);
    read_seq(2, "R7 read after repeated start");

    // R10: read wrap
    set_ptr(8'hFE, 1'b0);
    read_seq(3, "R10 read wraps FF to 00");
    read_seq(1, "R4 pointer continues between reads");

    // R10: write wrap
    set_ptr(8'hFF, 1'b0);
    write_data(2, 8'h3C);
    bus_stop();
    chk(reg_addr == 8'h01, "R10 write pointer wraps", reg_addr, 8'h01);
    set_ptr(8'hFF, 1'b0);
    read_seq(2, "R10 readback of wrapped writes");

    // R1: non-matching address, write and read direction
    bus_start();
    send_byte({OTHER, 1'b0}, a);
    chk(!a, "R1 no ack for other address", a, 0);
    send_byte(8'hFF, a);
    chk(!a, "R1 data ignored after mismatch", a, 0);
    bus_stop();
    chk(reg_addr == 8'(exp_ptr), "R1 pointer untouched by mismatch", reg_addr, exp_ptr);
    bus_start();
    send_byte({OTHER, 1'b1}, a);
    chk(!a, "R1 no ack for other read address", a, 0);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R1 slave silent on mismatched read", d, 8'hFF);
    bus_stop();

    // R9: stop in the middle of a data byte
    set_ptr(8'h20, 1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b0, lb);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 SDA released after mid-byte stop", sda_oe, 0);
    chk(reg_addr == 8'h20, "R9 pointer kept after mid-byte stop", reg_addr, 8'h20);
    read_seq(1, "R9 register unchanged after abort");

    // R8: start in the middle of a data byte
    set_ptr(8'h30, 1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b1, lb);
    read_seq(1, "R8 read after mid-byte start");

    // R8: start in the middle of the address byte
    wr_before = exp_ptr;
    bus_start();
    for (int i = 0; i < 5; i++) send_bit(1'b0, lb);
    read_seq(1, "R8 read after aborted address");
    chk(reg_addr == 8'(wr_before + 1), "R8 pointer kept through abort", reg_addr, wr_before + 1);

    repeat (10) @(negedge clk);
    chk(wq.size() == 0, "R3 all expected writes seen", wq.size(), 0);
    chk(rq.size() == 0, "R4 all expected fetches seen", rq.size(), 0);
    finish_run();
  end

endmodule